// File: doc/BRIEF.md
# JTAG Debug Access Bridge

This block is a boundary-scan test access port whose instruction register is four bits wide. Beyond the identification and bypass registers, it decodes a set of private instruction codes. These codes turn data-register scans into transactions on two system-side targets. One is a request/acknowledge debug module port with an 8-bit register address and 64-bit data. The other is a classic 64-bit Wishbone master.

The scan side runs on TCK. The bus side runs on the system clock. A transaction is launched at Update-DR and carried across the clock boundary by a four-phase request/acknowledge pair, with a two-flop synchroniser in each direction. The payload (target, direction, address and write data) is held stable for the whole handshake. Every transaction ends with a read of the addressed location, and the 64-bit result is stored on the TCK side. The next Capture-DR of any data instruction loads that stored result. A write scan therefore shifts out the value that stood at the address before the write. A later read scan returns the value read back after the write.

Top module: `jdb_bridge`

## Requirements
- R1: Asserting `trst`, or passing through Test-Logic-Reset, selects instruction 1. Its 32-bit data scan, least significant bit first, shifts out 0x000018FF.
- R2: The controller follows the 16-state boundary-scan graph. Five TCK edges with `tms` high reach Test-Logic-Reset from any state. An instruction scan shifts out the capture pattern 4'b0001, least significant bit first.
- R3: Codes 0, 2, 3, 4 and 11 to 15 select a 1-bit bypass stage that captures 0, so `tdo` repeats `tdi` one shift later.
- R4: Code 8 is an 8-bit scan whose capture shows the current debug-port address. At Update-DR the shifted-in value becomes the address, and a debug-port read of it is launched.
- R5: Code 9 is a 64-bit scan whose capture shows the result of the last completed transaction. Its Update-DR launches a fresh debug-port read at the held address.
- R6: Code 10 is a 64-bit scan whose capture shows the held result, which is the old value at the address. At Update-DR the shifted-in value is written to the debug port and then read back.
- R7: Code 5 is a 64-bit scan whose capture shows the current Wishbone word address. At Update-DR the shifted-in value becomes the address, and a Wishbone read of it is launched.
- R8: Code 6 is a 64-bit scan whose capture shows the held result, which is the Wishbone data at the address. Its Update-DR launches a new read.
- R9: Code 7 is a 64-bit scan whose capture shows the held result. At Update-DR the shifted-in value is written to the Wishbone address and then read back, so a following code 6 scan returns the written value.
- R10: `dmi_req` stays high, with address, data and direction steady, until `dmi_ack` arrives. It is low after reset and between transactions, and it is never high together with `wb_cyc`.
- R11: `wb_cyc` and `wb_stb` rise and fall together and stay high, with address and direction steady, until `wb_ack` arrives.
- R12: An Update-DR that arrives while a transaction is still in flight launches nothing. An address scan still updates the held address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock for the bus side |
| rst | input | 1 | Synchronous active-high reset, system clock domain |
| tck | input | 1 | Scan clock |
| trst | input | 1 | Synchronous active-high reset, scan clock domain |
| tms | input | 1 | Scan mode select |
| tdi | input | 1 | Scan data in |
| tdo | output | 1 | Scan data out, valid in the shift states |
| dmi_req | output | 1 | Debug-port request, held until acknowledge |
| dmi_wr | output | 1 | Debug-port direction, 1 = write |
| dmi_addr | output | 8 | Debug-port register address |
| dmi_wdata | output | 64 | Debug-port write data |
| dmi_rdata | input | 64 | Debug-port read data, valid with acknowledge |
| dmi_ack | input | 1 | Debug-port acknowledge, one cycle |
| wb_cyc | output | 1 | Wishbone cycle |
| wb_stb | output | 1 | Wishbone strobe |
| wb_we | output | 1 | Wishbone write enable |
| wb_sel | output | 8 | Wishbone byte selects, all set |
| wb_adr | output | 64 | Wishbone word address |
| wb_dat_o | output | 64 | Wishbone write data |
| wb_dat_i | input | 64 | Wishbone read data |
| wb_ack | input | 1 | Wishbone acknowledge |

## Verification
The hardest case to reach is a scan update that lands while an earlier transaction is still crossing the clock boundary. With a prompt target, a whole handshake finishes in fewer TCK cycles than the shortest scan. The bench therefore stretches its debug-port target so that each acknowledge comes only after thousands of system clocks. Inside that window it issues an address scan. It then confirms two things: the stored result is the read-back of the slow write, and a later read returns the untouched value at the new address.

// File: rtl/jdb_pkg.sv
`timescale 1ns/1ps
package jdb_pkg;

    localparam int IR_W    = 4;
    localparam int DATA_W  = 64;
    localparam int DMI_AW  = 8;
    localparam int WB_AW   = 64;
    localparam int SEL_W   = DATA_W / 8;
    localparam int LEN_W   = $clog2(DATA_W) + 1;
    localparam int IDX_W   = $clog2(DATA_W);

    localparam logic [IR_W-1:0] IR_IDCODE   = 4'd1;
    localparam logic [IR_W-1:0] IR_WB_ADDR  = 4'd5;
    localparam logic [IR_W-1:0] IR_WB_READ  = 4'd6;
    localparam logic [IR_W-1:0] IR_WB_WRRD  = 4'd7;
    localparam logic [IR_W-1:0] IR_DMI_ADDR = 4'd8;
    localparam logic [IR_W-1:0] IR_DMI_READ = 4'd9;
    localparam logic [IR_W-1:0] IR_DMI_WRRD = 4'd10;
    localparam logic [IR_W-1:0] IR_CAPTURE  = 4'b0001;

    typedef enum logic [3:0] {
        TAP_TLR, TAP_RTI,
        TAP_SEL_DR, TAP_CAP_DR, TAP_SH_DR, TAP_EX1_DR, TAP_PAU_DR, TAP_EX2_DR, TAP_UPD_DR,
        TAP_SEL_IR, TAP_CAP_IR, TAP_SH_IR, TAP_EX1_IR, TAP_PAU_IR, TAP_EX2_IR, TAP_UPD_IR
    } tap_state_t;

    typedef enum logic [1:0] {ENG_IDLE, ENG_WR, ENG_RD, ENG_HOLD} eng_state_t;

    typedef struct packed {
        logic              to_wb;
        logic              do_wr;
        logic [WB_AW-1:0]  addr;
        logic [DATA_W-1:0] wdata;
    } xfer_t;

    function automatic tap_state_t tap_next(input tap_state_t s, input logic m);
        case (s)
            TAP_TLR:    return m ? TAP_TLR    : TAP_RTI;
            TAP_RTI:    return m ? TAP_SEL_DR : TAP_RTI;
            TAP_SEL_DR: return m ? TAP_SEL_IR : TAP_CAP_DR;
            TAP_CAP_DR: return m ? TAP_EX1_DR : TAP_SH_DR;
            TAP_SH_DR:  return m ? TAP_EX1_DR : TAP_SH_DR;
            TAP_EX1_DR: return m ? TAP_UPD_DR : TAP_PAU_DR;
            TAP_PAU_DR: return m ? TAP_EX2_DR : TAP_PAU_DR;
            TAP_EX2_DR: return m ? TAP_UPD_DR : TAP_SH_DR;
            TAP_UPD_DR: return m ? TAP_SEL_DR : TAP_RTI;
            TAP_SEL_IR: return m ? TAP_TLR    : TAP_CAP_IR;
            TAP_CAP_IR: return m ? TAP_EX1_IR : TAP_SH_IR;
            TAP_SH_IR:  return m ? TAP_EX1_IR : TAP_SH_IR;
            TAP_EX1_IR: return m ? TAP_UPD_IR : TAP_PAU_IR;
            TAP_PAU_IR: return m ? TAP_EX2_IR : TAP_PAU_IR;
            TAP_EX2_IR: return m ? TAP_UPD_IR : TAP_SH_IR;
            default:    return m ? TAP_SEL_DR : TAP_RTI;
        endcase
    endfunction

    // Scan length selected by an instruction; unassigned codes give bypass
    function automatic logic [LEN_W-1:0] dr_len(input logic [IR_W-1:0] code);
        case (code)
            IR_IDCODE:   return LEN_W'(32);
            IR_DMI_ADDR: return LEN_W'(DMI_AW);
            IR_WB_ADDR, IR_WB_READ, IR_WB_WRRD,
            IR_DMI_READ, IR_DMI_WRRD: return LEN_W'(DATA_W);
            default:     return LEN_W'(1);
        endcase
    endfunction

endpackage

// File: rtl/jdb_sync2.sv
`timescale 1ns/1ps
module jdb_sync2 (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= 1'b0;
            q    <= 1'b0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/jdb_tap_ctrl.sv
`timescale 1ns/1ps
module jdb_tap_ctrl
    import jdb_pkg::*;
(
    input  logic       tck,
    input  logic       trst,
    input  logic       tms,
    output tap_state_t state
);
    always_ff @(posedge tck) begin
        if (trst) state <= TAP_TLR;
        else      state <= tap_next(state, tms);
    end
endmodule

// File: rtl/jdb_bus_engine.sv
`timescale 1ns/1ps
module jdb_bus_engine
    import jdb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_s,
    input  xfer_t             xfer,
    output logic              done,
    output logic [DATA_W-1:0] result,
    output logic              dmi_req,
    output logic              dmi_wr,
    output logic [DMI_AW-1:0] dmi_addr,
    output logic [DATA_W-1:0] dmi_wdata,
    input  logic [DATA_W-1:0] dmi_rdata,
    input  logic              dmi_ack,
    output logic              wb_cyc,
    output logic              wb_stb,
    output logic              wb_we,
    output logic [SEL_W-1:0]  wb_sel,
    output logic [WB_AW-1:0]  wb_adr,
    output logic [DATA_W-1:0] wb_dat_o,
    input  logic [DATA_W-1:0] wb_dat_i,
    input  logic              wb_ack
);
    eng_state_t st;
    logic       bus_ack;
    logic       active;

    assign bus_ack = xfer.to_wb ? wb_ack : dmi_ack;
    assign active  = (st == ENG_WR) || (st == ENG_RD);

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ENG_IDLE;
            result <= '0;
        end else begin
            case (st)
                ENG_IDLE: if (req_s) st <= xfer.do_wr ? ENG_WR : ENG_RD;
                ENG_WR:   if (bus_ack) st <= ENG_RD;
                ENG_RD:   if (bus_ack) begin
                              result <= xfer.to_wb ? wb_dat_i : dmi_rdata;
                              st     <= ENG_HOLD;
                          end
                default:  if (!req_s) st <= ENG_IDLE;
            endcase
        end
    end

    assign done      = (st == ENG_HOLD);
    assign dmi_req   = active && !xfer.to_wb;
    assign dmi_wr    = (st == ENG_WR);
    assign dmi_addr  = xfer.addr[DMI_AW-1:0];
    assign dmi_wdata = xfer.wdata;
    assign wb_cyc    = active && xfer.to_wb;
    assign wb_stb    = active && xfer.to_wb;
    assign wb_we     = (st == ENG_WR);
    assign wb_sel    = '1;
    assign wb_adr    = xfer.addr;
    assign wb_dat_o  = xfer.wdata;
endmodule

// File: rtl/jdb_bridge.sv
`timescale 1ns/1ps
module jdb_bridge
    import jdb_pkg::*;
#(
    parameter logic [31:0] ID_VALUE = 32'h0000_18FF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tck,
    input  logic              trst,
    input  logic              tms,
    input  logic              tdi,
    output logic              tdo,
    output logic              dmi_req,
    output logic              dmi_wr,
    output logic [7:0]        dmi_addr,
    output logic [63:0]       dmi_wdata,
    input  logic [63:0]       dmi_rdata,
    input  logic              dmi_ack,
    output logic              wb_cyc,
    output logic              wb_stb,
    output logic              wb_we,
    output logic [7:0]        wb_sel,
    output logic [63:0]       wb_adr,
    output logic [63:0]       wb_dat_o,
    input  logic [63:0]       wb_dat_i,
    input  logic              wb_ack
);
    tap_state_t        tap_state;
    logic [IR_W-1:0]   ir_q, ir_sr;
    logic [DATA_W-1:0] dr_sr, dr_nxt, cap_val;
    logic [DMI_AW-1:0] dmi_addr_q;
    logic [WB_AW-1:0]  wb_addr_q;
    logic [DATA_W-1:0] result_t, eng_result;
    logic              req_t, req_s, ack_t, eng_done;
    xfer_t             xfer_q, launch_xfer;
    logic              launch;
    logic [LEN_W-1:0]  len;
    logic [IDX_W-1:0]  top_idx;

    jdb_tap_ctrl u_tap (.tck(tck), .trst(trst), .tms(tms), .state(tap_state));

    // Captured value per instruction
    always_comb begin
        case (ir_q)
            IR_IDCODE:   cap_val = DATA_W'(ID_VALUE);
            IR_DMI_ADDR: cap_val = DATA_W'(dmi_addr_q);
            IR_WB_ADDR:  cap_val = wb_addr_q;
            IR_WB_READ, IR_WB_WRRD,
            IR_DMI_READ, IR_DMI_WRRD: cap_val = result_t;
            default:     cap_val = '0;
        endcase
    end

    // Right shift; tdi enters at the top bit of the selected length
    always_comb begin
        len     = dr_len(ir_q);
        top_idx = IDX_W'(len - LEN_W'(1));
        dr_nxt  = {1'b0, dr_sr[DATA_W-1:1]};
        dr_nxt[top_idx] = tdi;
    end

    always_comb begin
        launch = (tap_state == TAP_UPD_DR) && (ir_q >= IR_WB_ADDR) && (ir_q <= IR_DMI_WRRD);
        launch_xfer.to_wb = (ir_q <= IR_WB_WRRD);
        launch_xfer.do_wr = (ir_q == IR_WB_WRRD) || (ir_q == IR_DMI_WRRD);
        launch_xfer.wdata = dr_sr;
        if (launch_xfer.to_wb)
            launch_xfer.addr = (ir_q == IR_WB_ADDR) ? dr_sr : wb_addr_q;
        else
            launch_xfer.addr = WB_AW'((ir_q == IR_DMI_ADDR) ? dr_sr[DMI_AW-1:0] : dmi_addr_q);
    end

    always_ff @(posedge tck) begin
        if (trst) begin
            ir_q       <= IR_IDCODE;
            ir_sr      <= '0;
            dr_sr      <= '0;
            dmi_addr_q <= '0;
            wb_addr_q  <= '0;
            result_t   <= '0;
            req_t      <= 1'b0;
            xfer_q     <= '0;
        end else begin
            case (tap_state)
                TAP_TLR:    ir_q  <= IR_IDCODE;
                TAP_CAP_IR: ir_sr <= IR_CAPTURE;
                TAP_SH_IR:  ir_sr <= {tdi, ir_sr[IR_W-1:1]};
                TAP_UPD_IR: ir_q  <= ir_sr;
                TAP_CAP_DR: dr_sr <= cap_val;
                TAP_SH_DR:  dr_sr <= dr_nxt;
                TAP_UPD_DR: begin
                    if (ir_q == IR_DMI_ADDR) dmi_addr_q <= dr_sr[DMI_AW-1:0];
                    if (ir_q == IR_WB_ADDR)  wb_addr_q  <= dr_sr;
                end
                default: ;
            endcase
            // Four-phase handshake, scan side
            if (req_t && ack_t) begin
                result_t <= eng_result;
                req_t    <= 1'b0;
            end else if (launch && !req_t && !ack_t) begin
                req_t  <= 1'b1;
                xfer_q <= launch_xfer;
            end
        end
    end

    always_comb begin
        case (tap_state)
            TAP_SH_IR: tdo = ir_sr[0];
            TAP_SH_DR: tdo = dr_sr[0];
            default:   tdo = 1'b0;
        endcase
    end

    jdb_sync2 u_req_sync (.clk(clk), .rst(rst),  .d(req_t),    .q(req_s));
    jdb_sync2 u_ack_sync (.clk(tck), .rst(trst), .d(eng_done), .q(ack_t));

    jdb_bus_engine u_eng (
        .clk(clk), .rst(rst), .req_s(req_s), .xfer(xfer_q),
        .done(eng_done), .result(eng_result),
        .dmi_req(dmi_req), .dmi_wr(dmi_wr), .dmi_addr(dmi_addr),
        .dmi_wdata(dmi_wdata), .dmi_rdata(dmi_rdata), .dmi_ack(dmi_ack),
        .wb_cyc(wb_cyc), .wb_stb(wb_stb), .wb_we(wb_we), .wb_sel(wb_sel),
        .wb_adr(wb_adr), .wb_dat_o(wb_dat_o), .wb_dat_i(wb_dat_i), .wb_ack(wb_ack)
    );
endmodule

// File: rtl/jdb_bridge_chk.sv
`timescale 1ns/1ps
module jdb_bridge_chk
    import jdb_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            tck,
    input logic            trst,
    input logic            tms,
    input tap_state_t      tap_state,
    input logic [IR_W-1:0] ir_q,
    input logic            dmi_req,
    input logic            dmi_ack,
    input logic            dmi_wr,
    input logic [7:0]      dmi_addr,
    input logic [63:0]     dmi_wdata,
    input logic            wb_cyc,
    input logic            wb_stb,
    input logic            wb_we,
    input logic            wb_ack,
    input logic [63:0]     wb_adr
);
    logic [2:0] tms_run;

    always_ff @(posedge tck) begin
        if (trst)     tms_run <= '0;
        else if (tms) tms_run <= (tms_run == 3'd7) ? tms_run : tms_run + 3'd1;
        else          tms_run <= '0;
    end

    AST_IR_RESET_ID: assert property (@(posedge tck) disable iff (trst)
        (tap_state == TAP_TLR) |=> (ir_q == IR_IDCODE)); // R1
    AST_TMS5_TLR: assert property (@(posedge tck) disable iff (trst)
        (tms_run >= 3'd5) |-> (tap_state == TAP_TLR)); // R2
    AST_DMI_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (dmi_req && !dmi_ack) |=> dmi_req); // R10
    AST_DMI_STABLE: assert property (@(posedge clk) disable iff (rst)
        (dmi_req && !dmi_ack) |=> ($stable(dmi_addr) && $stable(dmi_wdata) && $stable(dmi_wr))); // R10
    AST_ONE_BUS: assert property (@(posedge clk) disable iff (rst)
        !(dmi_req && wb_cyc)); // R10
    AST_WB_HOLD: assert property (@(posedge clk) disable iff (rst)
        (wb_cyc && !wb_ack) |=> (wb_cyc && $stable(wb_adr) && $stable(wb_we))); // R11
    AST_WB_STB_CYC: assert property (@(posedge clk) disable iff (rst)
        (wb_stb == wb_cyc)); // R11
endmodule

bind jdb_bridge jdb_bridge_chk chk_i (
    .clk(clk), .rst(rst), .tck(tck), .trst(trst), .tms(tms),
    .tap_state(tap_state), .ir_q(ir_q),
    .dmi_req(dmi_req), .dmi_ack(dmi_ack), .dmi_wr(dmi_wr),
    .dmi_addr(dmi_addr), .dmi_wdata(dmi_wdata),
    .wb_cyc(wb_cyc), .wb_stb(wb_stb), .wb_we(wb_we), .wb_ack(wb_ack), .wb_adr(wb_adr)
);

// File: tb/jdb_bridge_tb_top.sv
`timescale 1ns/1ps
module jdb_bridge_tb_top;
    logic clk = 1'b0, rst = 1'b1, tck = 1'b0, trst = 1'b1, tms = 1'b1, tdi = 1'b0;
    logic tdo;
    logic dmi_req, dmi_wr, dmi_ack;
    logic [7:0]  dmi_addr;
    logic [63:0] dmi_wdata, dmi_rdata;
    logic wb_cyc, wb_stb, wb_we, wb_ack;
    logic [7:0]  wb_sel;
    logic [63:0] wb_adr, wb_dat_o, wb_dat_i;

    int n_checks = 0, n_err = 0, dmi_lat = 0, dmi_cnt = 0;
    bit finished = 1'b0;
    logic [63:0] dmi_mem [256];
    logic [63:0] wb_mem  [16];

    always #2.5 clk = ~clk;

    jdb_bridge dut_i (
        .clk(clk), .rst(rst), .tck(tck), .trst(trst), .tms(tms), .tdi(tdi), .tdo(tdo),
        .dmi_req(dmi_req), .dmi_wr(dmi_wr), .dmi_addr(dmi_addr), .dmi_wdata(dmi_wdata),
        .dmi_rdata(dmi_rdata), .dmi_ack(dmi_ack),
        .wb_cyc(wb_cyc), .wb_stb(wb_stb), .wb_we(wb_we), .wb_sel(wb_sel), .wb_adr(wb_adr),
        .wb_dat_o(wb_dat_o), .wb_dat_i(wb_dat_i), .wb_ack(wb_ack)
    );

    function automatic logic [63:0] dmi_init(input int a);
        return 64'h9E37_79B9_7F4A_7C15 * 64'(a + 1);
    endfunction
    function automatic logic [63:0] wb_init(input int i);
        return {32'hC0DE_0000 | 32'(i), 32'h600D_0000 ^ 32'(i * 3)};
    endfunction

    // Debug-port target with adjustable acknowledge latency
    always @(posedge clk) begin
        if (rst) begin
            for (int a = 0; a < 256; a++) dmi_mem[a] <= dmi_init(a);
            dmi_ack <= 1'b0; dmi_rdata <= '0; dmi_cnt <= 0;
        end else if (dmi_req && !dmi_ack) begin
            if (dmi_cnt >= dmi_lat) begin
                dmi_ack <= 1'b1; dmi_cnt <= 0;
                if (dmi_wr) dmi_mem[dmi_addr] <= dmi_wdata;
                dmi_rdata <= dmi_mem[dmi_addr];
            end else dmi_cnt <= dmi_cnt + 1;
        end else dmi_ack <= 1'b0;
    end

    // Wishbone memory, word index from the low address bits
    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 16; i++) wb_mem[i] <= wb_init(i);
            wb_ack <= 1'b0; wb_dat_i <= '0;
        end else if (wb_cyc && wb_stb && !wb_ack) begin
            wb_ack <= 1'b1;
            if (wb_we) wb_mem[wb_adr[3:0]] <= wb_dat_o;
            wb_dat_i <= wb_mem[wb_adr[3:0]];
        end else wb_ack <= 1'b0;
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick(input logic m, input logic d, output logic o);
        tms = m; tdi = d;
        #10; o = tdo;
        #10; tck = 1'b1;
        #20; tck = 1'b0;
    endtask

    task automatic idle(input int k);
        logic o;
        for (int i = 0; i < k; i++) tick(1'b0, 1'b0, o);
    endtask

    task automatic tap_reset();
        logic o;
        for (int i = 0; i < 5; i++) tick(1'b1, 1'b0, o);
        tick(1'b0, 1'b0, o);
    endtask

    task automatic scan_ir(input logic [3:0] code, output logic [3:0] dout);
        logic o;
        dout = '0;
        tick(1'b1, 1'b0, o); tick(1'b1, 1'b0, o); tick(1'b0, 1'b0, o); tick(1'b0, 1'b0, o);
        for (int i = 0; i < 4; i++) begin tick(i == 3, code[i], o); dout[i] = o; end
        tick(1'b1, 1'b0, o); tick(1'b0, 1'b0, o);
    endtask

    task automatic scan_dr(input int n, input logic [63:0] din, output logic [63:0] dout);
        logic o;
        dout = '0;
        tick(1'b1, 1'b0, o); tick(1'b0, 1'b0, o); tick(1'b0, 1'b0, o);
        for (int i = 0; i < n; i++) begin tick(i == n - 1, din[i], o); dout[i] = o; end
        tick(1'b1, 1'b0, o); tick(1'b0, 1'b0, o);
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_checks++; n_err++;
        $display("FAIL watchdog actual=running expected=finished");
        report();
    end

    initial begin
        logic [3:0]  ir_out;
        logic [63:0] d_out;
        logic [7:0]  prev_da;
        logic [63:0] prev_wa;
        logic o;
        for (int i = 0; i < 4; i++) tick(1'b1, 1'b0, o);
        rst = 1'b0; trst = 1'b0;
        tick(1'b0, 1'b0, o);

        // Reset state: idle buses, quiet tdo
        chk("R10 reset dmi_req", 64'(dmi_req), 64'd0);
        chk("R10 reset wb_cyc", 64'(wb_cyc), 64'd0);
        chk("R10 reset tdo", 64'(tdo), 64'd0);

        scan_dr(32, 64'hFFFF_FFFF, d_out);
        chk("R1 id after trst", d_out, 64'h18FF);

        scan_ir(4'd3, ir_out);
        chk("R2 ir capture", 64'(ir_out), 64'h1);
        tap_reset();
        scan_dr(32, 64'h0, d_out);
        chk("R2 id after five tms", d_out, 64'h18FF);

        // Bypass sweep over every unassigned code
        for (int c = 0; c < 16; c++) begin
            if (c == 1 || (c >= 5 && c <= 10)) continue;
            scan_ir(4'(c), ir_out);
            scan_dr(8, 64'(8'h5A ^ 8'(c * 17)), d_out);
            chk($sformatf("R3 bypass code %0d", c), d_out,
                64'({7'(8'h5A ^ 8'(c * 17)), 1'b0}));
        end

        // Debug-port address and read sweep
        prev_da = 8'h00;
        for (int k = 0; k < 5; k++) begin
            logic [7:0] a;
            a = 8'((k * 85 + 3) & 255);
            scan_ir(4'd8, ir_out);
            scan_dr(8, 64'(a), d_out);
            chk("R4 dmi addr capture", d_out, 64'(prev_da));
            prev_da = a;
            idle(16);
            scan_ir(4'd9, ir_out);
            scan_dr(64, 64'h0, d_out);
            chk("R5 dmi read", d_out, dmi_init(int'(a)));
        end

        // Debug-port write returns old value, then read shows new
        scan_ir(4'd8, ir_out);
        scan_dr(8, 64'h21, d_out);
        idle(16);
        scan_ir(4'd10, ir_out);
        scan_dr(64, 64'hFEED_0000_CAFE_0021, d_out);
        chk("R6 dmi write old value", d_out, dmi_init(33));
        idle(16);
        scan_ir(4'd9, ir_out);
        scan_dr(64, 64'h0, d_out);
        chk("R6 dmi write readback", d_out, 64'hFEED_0000_CAFE_0021);

        // Wishbone sweep
        prev_wa = '0;
        for (int i = 0; i < 8; i++) begin
            logic [63:0] wa, wv;
            wa = 64'h0000_0100_0000_0000 | 64'(i * 2 + 1);
            wv = 64'hA5A5_0000_0000_0000 | 64'(i * 7919);
            scan_ir(4'd5, ir_out);
            scan_dr(64, wa, d_out);
            chk("R7 wb addr capture", d_out, prev_wa);
            prev_wa = wa;
            idle(16);
            scan_ir(4'd6, ir_out);
            scan_dr(64, 64'h0, d_out);
            chk("R8 wb read", d_out, wb_init(i * 2 + 1));
            idle(16);
            scan_ir(4'd7, ir_out);
            scan_dr(64, wv, d_out);
            chk("R9 wb write old value", d_out, wb_init(i * 2 + 1));
            idle(16);
            scan_ir(4'd6, ir_out);
            scan_dr(64, 64'h0, d_out);
            chk("R9 wb readback", d_out, wv);
        end

        // Update while busy: slow debug port, address scan inside the window
        scan_ir(4'd8, ir_out);
        scan_dr(8, 64'h40, d_out);
        idle(16);
        dmi_lat = 2000;
        scan_ir(4'd10, ir_out);
        scan_dr(64, 64'h1234_5678_9ABC_DEF0, d_out);
        chk("R12 slow write old value", d_out, dmi_init(64));
        scan_ir(4'd8, ir_out);
        scan_dr(8, 64'h33, d_out);
        chk("R12 addr capture while busy", d_out, 64'h40);
        idle(700);
        dmi_lat = 0;
        scan_ir(4'd9, ir_out);
        scan_dr(64, 64'h0, d_out);
        chk("R12 dropped read, result of slow write", d_out, 64'h1234_5678_9ABC_DEF0);
        idle(16);
        scan_dr(64, 64'h0, d_out);
        chk("R12 new address kept and untouched", d_out, dmi_init(51));

        report();
    end
endmodule